// File: doc/BRIEF.md
# Tape DMA Address and Byte Counter

This block keeps the books for direct memory transfers between a tape data path and system memory. Software first loads a transfer counter with the negative of the number of characters, a 16-bit word address and two extension bits that make it an 18-bit address. After that, each tape character moves through the block. When the tape is read, incoming bytes are packed into 16-bit words and written to memory. When the tape is written, words are fetched from memory and handed out one byte per demand strobe. A request/grant and master/slave-sync handshake carries each word.

The counter counts up towards zero and stops the transfer there. A read that runs past zero raises a record-length error and ignores the rest of the record. A write that runs past zero signals the end of the record. A late bus grant or a missing slave sync stops all further transfers and leaves the address pointing at the word that failed. In space operations the counter counts records, one per parity-character strobe, and ignores data characters.

Top module: `tape_dma_counter`

## Requirements
- R1: `ld_cnt` loads `cnt` from `wdata` and clears all three error flags. Each accepted data character then raises `cnt` by exactly one.
- R2: In tape-write mode (`xfer_to_tape`=1), a demand strobe that arrives while `cnt` is 0 gives a one-cycle `rec_end` pulse and no `chr_out_vld`.
- R3: In tape-read mode, a character that arrives while `cnt` is 0 sets `err_rle`. The character causes no memory write, and the counter and the address do not change.
- R4: Each completed memory word transfer raises the 18-bit `addr` by 2. A carry out of bit 15 propagates into bits 17:16.
- R5: After reset, `cnt`, `addr`, all error flags, `bus_req` and `msyn` are 0. `ld_addr` loads bits 15:0 with bit 0 forced to 0, and `ld_ext` loads bits 17:16 from `wdata[1:0]`.
- R6: A data character that arrives while a bus transfer is still outstanding sets `err_bgl`. A write demand that arrives before its word has been fetched also sets `err_bgl`. While the flag is set, no bus request is made and no demand is answered, and `addr` keeps the failing address.
- R7: If `bus_ssyn` has not answered after NXM_CYCLES cycles of `msyn`, the block sets `err_nxm` and drops `msyn`. `addr` keeps the failing address.
- R8: Bytes alternate between the two halves of a word. With `hi_first`=0 the first byte of a word goes to bits 7:0; with `hi_first`=1 it goes to bits 15:8. The last byte of a record forces out a partly filled word, with its empty half set to 0.
- R9: With `space_op`=1, each `lpc_stb` raises `cnt` by one. Data characters are ignored and start no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables transfers |
| xfer_to_tape | input | 1 | 1: memory to tape, 0: tape to memory |
| space_op | input | 1 | Counts records instead of characters |
| hi_first | input | 1 | Byte order within a word |
| ld_cnt | input | 1 | Load counter, clear errors |
| ld_addr | input | 1 | Load address bits 15:0 |
| ld_ext | input | 1 | Load address bits 17:16 |
| wdata | input | 16 | Load value |
| chr_stb | input | 1 | Tape character strobe or write demand |
| chr_in | input | 8 | Byte read from tape |
| lpc_stb | input | 1 | Parity-character strobe (spacing) |
| chr_out | output | 8 | Byte to write on tape |
| chr_out_vld | output | 1 | `chr_out` valid pulse |
| rec_end | output | 1 | Write record finished |
| cnt | output | 16 | Byte/record counter |
| addr | output | 18 | Current memory address |
| err_rle | output | 1 | Record-length error |
| err_bgl | output | 1 | Bus-grant-late error |
| err_nxm | output | 1 | Non-existent-memory error |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| msyn | output | 1 | Master sync |
| bus_ssyn | input | 1 | Slave sync |
| bus_wr | output | 1 | 1: memory write |
| bus_addr | output | 18 | Memory address |
| bus_wdata | output | 16 | Memory write word |
| bus_rdata | input | 16 | Memory read word |

## Verification
The bench builds the block with NXM_CYCLES=16 instead of the default of 1250, which is 10 microseconds at the design clock. With this value the slave-sync timeout expires within a few dozen cycles, so the failing-address hold can be checked. A memory model in the bench can hold off its grant for 20 cycles, which makes late-grant errors appear in both directions. A separate setting keeps it from ever answering.

// File: rtl/tape_dma_counter.sv
module tape_dma_counter #(
  parameter int NXM_CYCLES = 1250
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        xfer_to_tape,
  input  logic        space_op,
  input  logic        hi_first,
  input  logic        ld_cnt,
  input  logic        ld_addr,
  input  logic        ld_ext,
  input  logic [15:0] wdata,
  input  logic        chr_stb,
  input  logic [7:0]  chr_in,
  input  logic        lpc_stb,
  output logic [7:0]  chr_out,
  output logic        chr_out_vld,
  output logic        rec_end,
  output logic [15:0] cnt,
  output logic [17:0] addr,
  output logic        err_rle,
  output logic        err_bgl,
  output logic        err_nxm,
  output logic        bus_req,
  input  logic        bus_gnt,
  output logic        msyn,
  input  logic        bus_ssyn,
  output logic        bus_wr,
  output logic [17:0] bus_addr,
  output logic [15:0] bus_wdata,
  input  logic [15:0] bus_rdata
);
  localparam int TW = $clog2(NXM_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_SYNC} st_t;
  st_t st;

  logic [15:0] asm_q, wbuf, owd;
  logic [17:0] adr;
  logic        ph, wbuf_vld;
  logic [TW-1:0] tmr;

  wire err_any = err_rle | err_bgl | err_nxm;
  wire busy    = st != S_IDLE;
  wire stb     = chr_stb & run & ~space_op & ~err_any & ~ld_cnt;
  wire zero    = cnt == 16'd0;
  wire last    = cnt == 16'hFFFF;
  wire late    = stb & ~zero & (busy | (xfer_to_tape & ~wbuf_vld));
  wire take    = stb & ~zero & ~late;
  wire rle_hit = stb & zero & ~xfer_to_tape;
  wire end_hit = stb & zero & xfer_to_tape;
  wire lane_hi = ph ^ hi_first;
  wire flush   = ph | last;
  wire fetch   = run & ~space_op & xfer_to_tape & ~err_any & ~ld_cnt
               & ~busy & ~wbuf_vld & ~zero;
  wire [15:0] asm_nx = lane_hi ? {chr_in, asm_q[7:0]} : {asm_q[15:8], chr_in};

  assign addr      = adr;
  assign bus_addr  = adr;
  assign bus_req   = st == S_REQ;
  assign msyn      = st == S_SYNC;
  assign bus_wr    = ~xfer_to_tape;
  assign bus_wdata = owd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; adr <= '0; asm_q <= '0; wbuf <= '0; owd <= '0;
      ph <= 1'b0; wbuf_vld <= 1'b0; tmr <= '0; chr_out <= '0;
      chr_out_vld <= 1'b0; rec_end <= 1'b0;
      err_rle <= 1'b0; err_bgl <= 1'b0; err_nxm <= 1'b0;
    end else begin
      chr_out_vld <= 1'b0;
      rec_end     <= 1'b0;
      if (ld_cnt) begin
        cnt <= wdata; err_rle <= 1'b0; err_bgl <= 1'b0; err_nxm <= 1'b0;
        ph <= 1'b0; wbuf_vld <= 1'b0; asm_q <= '0;
      end else begin
        if (run && space_op && lpc_stb) cnt <= cnt + 16'd1;
        if (rle_hit) err_rle <= 1'b1;
        if (late)    err_bgl <= 1'b1;
        if (end_hit) rec_end <= 1'b1;
        if (take) begin
          cnt <= cnt + 16'd1;
          if (xfer_to_tape) begin
            chr_out     <= lane_hi ? wbuf[15:8] : wbuf[7:0];
            chr_out_vld <= 1'b1;
            if (flush) begin wbuf_vld <= 1'b0; ph <= 1'b0; end
            else ph <= 1'b1;
          end else if (flush) begin
            owd <= asm_nx; asm_q <= '0; ph <= 1'b0;
          end else begin
            asm_q <= asm_nx; ph <= 1'b1;
          end
        end
      end
      if (ld_addr) adr[15:0]  <= {wdata[15:1], 1'b0};
      if (ld_ext)  adr[17:16] <= wdata[1:0];
      case (st)
        S_IDLE:
          if ((take && !xfer_to_tape && flush) || fetch) st <= S_REQ;
        S_REQ:
          if (late) st <= S_IDLE;
          else if (bus_gnt) begin st <= S_SYNC; tmr <= '0; end
        S_SYNC:
          if (late) st <= S_IDLE;
          else if (bus_ssyn) begin
            st  <= S_IDLE;
            adr <= adr + 18'd2;
            if (xfer_to_tape) begin wbuf <= bus_rdata; wbuf_vld <= 1'b1; end
          end else if (tmr == TW'(NXM_CYCLES - 1)) begin
            err_nxm <= 1'b1; st <= S_IDLE;
          end else tmr <= tmr + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module tape_dma_counter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic        xfer_to_tape,
  input logic        space_op,
  input logic        ld_cnt,
  input logic        ld_addr,
  input logic        ld_ext,
  input logic        chr_stb,
  input logic [15:0] cnt,
  input logic [17:0] addr,
  input logic        err_rle,
  input logic        err_bgl,
  input logic        err_nxm,
  input logic        bus_req,
  input logic        msyn,
  input logic        bus_ssyn,
  input logic        chr_out_vld,
  input logic        rec_end
);
  wire clean = !err_rle && !err_bgl && !err_nxm && !ld_cnt;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    chr_out_vld |-> cnt == $past(cnt) + 16'd1); // R1

  AST_WR_END: assert property (@(posedge clk) disable iff (!rst_n)
    chr_stb && run && !space_op && xfer_to_tape && cnt == 16'd0 && clean
    |=> rec_end && !chr_out_vld); // R2

  AST_RLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    chr_stb && run && !space_op && !xfer_to_tape && cnt == 16'd0 && clean
    |=> err_rle); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    msyn && bus_ssyn && !chr_stb && !ld_addr && !ld_ext
    |=> addr == $past(addr) + 18'd2); // R4

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (err_bgl || err_nxm) && !ld_cnt |=> !bus_req && !msyn && !chr_out_vld); // R6

  AST_NXM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_nxm) && !$past(ld_addr) && !$past(ld_ext) |-> addr == $past(addr)); // R7
endmodule

bind tape_dma_counter tape_dma_counter_chk u_chk (.*);

// File: tb/tape_dma_counter_tb.sv
module tape_dma_counter_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic run = 0, xfer_to_tape = 0, space_op = 0, hi_first = 0;
  logic ld_cnt = 0, ld_addr = 0, ld_ext = 0;
  logic [15:0] wdata = '0;
  logic chr_stb = 0, lpc_stb = 0;
  logic [7:0] chr_in = '0;
  logic [7:0] chr_out;
  logic chr_out_vld, rec_end, err_rle, err_bgl, err_nxm, bus_req, msyn, bus_wr;
  logic [15:0] cnt, bus_wdata;
  logic [17:0] addr, bus_addr;
  logic bus_gnt = 0, bus_ssyn = 0;
  logic [15:0] bus_rdata = '0;

  int checks = 0, errors = 0;
  int gnt_dly = 0, gwait = 0;
  bit mem_dead = 0, done = 0;
  logic seen_end;
  logic [15:0] mem [0:63];
  logic [33:0] exp_wr [$];
  logic [7:0]  exp_chr [$];

  always #4 clk = ~clk;

  tape_dma_counter #(.NXM_CYCLES(16)) u_dut (.*);

  task automatic chk(string tag, logic [33:0] act, logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      bus_gnt = 0; bus_ssyn = 0;
      if (bus_req) begin
        if (gwait >= gnt_dly) begin bus_gnt = 1; gwait = 0; end
        else gwait++;
      end else gwait = 0;
      if (msyn && !mem_dead) begin
        bus_ssyn = 1;
        if (bus_wr) begin
          mem[bus_addr[6:1]] = bus_wdata;
          checks++;
          if (exp_wr.size() == 0) begin
            errors++;
            $display("FAIL R8 unexpected write act=%h exp=none", {bus_addr, bus_wdata});
          end else chk("R8 R4 memory write", {bus_addr, bus_wdata}, exp_wr.pop_front());
        end else bus_rdata = mem[bus_addr[6:1]];
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      if (chr_out_vld) begin
        if (exp_chr.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6 unexpected tape byte act=%h exp=none", chr_out);
        end else chk("R8 tape byte", {26'd0, chr_out}, {26'd0, exp_chr.pop_front()});
      end
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(logic [15:0] c, logic [17:0] a, logic wr, logic sp, logic hi);
    @(negedge clk);
    run = 0; xfer_to_tape = wr; space_op = sp; hi_first = hi;
    ld_cnt = 1; wdata = c;
    @(negedge clk); ld_cnt = 0; ld_addr = 1; wdata = a[15:0];
    @(negedge clk); ld_addr = 0; ld_ext = 1; wdata = {14'd0, a[17:16]};
    @(negedge clk); ld_ext = 0; run = 1;
  endtask

  task automatic send(logic [7:0] b, int gap);
    @(negedge clk); chr_stb = 1; chr_in = b;
    @(negedge clk); chr_stb = 0; seen_end = rec_end;
    cycles(gap);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL all: watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    cycles(3);
    chk("R5 reset cnt", {18'd0, cnt}, 34'd0);
    chk("R5 reset addr", {16'd0, addr}, 34'd0);
    chk("R5 reset errors", {31'd0, err_rle, err_bgl, err_nxm}, 34'd0);
    chk("R5 reset bus idle", {32'd0, bus_req, msyn}, 34'd0);
    rst_n = 1;
    cycles(2);

    // R8 low-first read, R5 bit 0 masked on load
    setup(16'hFFFC, 18'h00101, 0, 0, 0);
    chk("R5 addr bit0", {16'd0, addr}, 34'h00100);
    exp_wr.push_back({18'h00100, 16'h2211});
    exp_wr.push_back({18'h00102, 16'h4433});
    send(8'h11, 6); send(8'h22, 6); send(8'h33, 6); send(8'h44, 6);
    chk("R1 count reached zero", {18'd0, cnt}, 34'd0);
    chk("R4 addr after two words", {16'd0, addr}, 34'h00104);

    // R8 high-first read with a final partial word, then R3
    setup(16'hFFFD, 18'h00200, 0, 0, 1);
    exp_wr.push_back({18'h00200, 16'hAABB});
    exp_wr.push_back({18'h00202, 16'hCC00});
    send(8'hAA, 6); send(8'hBB, 6); send(8'hCC, 6);
    chk("R8 partial word addr", {16'd0, addr}, 34'h00204);
    send(8'hDD, 6);
    chk("R3 rle set", {33'd0, err_rle}, 34'd1);
    chk("R3 count held", {18'd0, cnt}, 34'd0);
    chk("R3 addr held", {16'd0, addr}, 34'h00204);

    // R4 carry into extension bits
    setup(16'hFFFE, 18'h0FFFE, 0, 0, 0);
    exp_wr.push_back({18'h0FFFE, 16'h0201});
    send(8'h01, 6); send(8'h02, 6);
    chk("R4 carry into ext", {16'd0, addr}, 34'h10000);
    chk("R1 errors cleared on load", {33'd0, err_rle}, 34'd0);

    setup(16'hFFFE, 18'h20010, 0, 0, 1);
    exp_wr.push_back({18'h20010, 16'h5566});
    send(8'h55, 6); send(8'h66, 6);
    chk("R5 ext load and step", {16'd0, addr}, 34'h20012);

    // R2 tape write, low first
    mem[32] = 16'h5A3C; mem[33] = 16'h7E81;
    setup(16'hFFFD, 18'h00040, 1, 0, 0);
    cycles(6);
    exp_chr.push_back(8'h3C); exp_chr.push_back(8'h5A); exp_chr.push_back(8'h81);
    send(8'h00, 6); send(8'h00, 6); send(8'h00, 6);
    chk("R1 write count zero", {18'd0, cnt}, 34'd0);
    send(8'h00, 6);
    chk("R2 rec_end pulse", {33'd0, seen_end}, 34'd1);
    chk("R2 fetch addr", {16'd0, addr}, 34'h00044);
    chk("R2 no error", {31'd0, err_rle, err_bgl, err_nxm}, 34'd0);

    // R6 late grant, read direction
    gnt_dly = 20;
    setup(16'hFFFC, 18'h00080, 0, 0, 0);
    send(8'h01, 2); send(8'h02, 2); send(8'h03, 2);
    chk("R6 bgl on read", {33'd0, err_bgl}, 34'd1);
    chk("R6 addr held", {16'd0, addr}, 34'h00080);
    cycles(25);
    chk("R6 no request after bgl", {32'd0, bus_req, msyn}, 34'd0);

    // R6 late grant, write direction: demands go unanswered
    setup(16'hFFFE, 18'h00040, 1, 0, 0);
    send(8'h00, 2); send(8'h00, 2);
    chk("R6 bgl on write", {33'd0, err_bgl}, 34'd1);
    chk("R6 count unchanged", {18'd0, cnt}, 34'h0FFFE);
    gnt_dly = 0;

    // R7 no slave sync
    mem_dead = 1;
    setup(16'hFFFE, 18'h01234, 0, 0, 0);
    send(8'h01, 2); send(8'h02, 30);
    chk("R7 nxm set", {33'd0, err_nxm}, 34'd1);
    chk("R7 addr held", {16'd0, addr}, 34'h01234);
    chk("R7 sync dropped", {33'd0, msyn}, 34'd0);
    mem_dead = 0;

    // R9 spacing
    setup(16'hFFFE, 18'h00000, 0, 1, 0);
    send(8'h77, 3);
    chk("R9 data ignored", {18'd0, cnt}, 34'h0FFFE);
    chk("R9 no bus activity", {32'd0, bus_req, msyn}, 34'd0);
    repeat (2) begin
      @(negedge clk); lpc_stb = 1;
      @(negedge clk); lpc_stb = 0;
    end
    chk("R9 records counted", {18'd0, cnt}, 34'd0);

    cycles(4);
    chk("R8 all writes seen", 34'(exp_wr.size()), 34'd0);
    chk("R8 all bytes seen", 34'(exp_chr.size()), 34'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule